// File: doc/BRIEF.md
# Fractional serial baud rate generator

This block turns a prescaled system clock into the timing strobes for one serial channel. One of several prescaler taps feeds a counter that divides by a 4-bit integer N, where N = 0 is read as 16. In asynchronous (UART) mode the divider output is the 16x oversampling strobe, and a further divide by 16 gives the bit strobe. In synchronous I/O mode the divider output is the bit strobe itself. UART mode also offers a fractional setting. It stretches some of the periods so that the average divisor becomes N + (16 − K)/16.

An external serial clock can take the place of the internal source. It is resynchronised, and each rising edge gives one source strobe. In UART mode that strobe runs at the 16x rate. In I/O mode it is used directly as the bit strobe. Settings that change while the block runs take effect only at the end of the current divider period.

Top module: `frac_baud_gen`

## Requirements
- R1: While rst_ni is low, and until the first divider period after release completes, os_tick_o and bit_tick_o are 0.
- R2: tap_sel_i selects the source rate: code 0 uses every clock, 1 every 4th, 2 every 16th, 3 every 64th.
- R3: In I/O mode (uart_mode_i = 0) with the internal source, bit_tick_o has a period of tap × N clocks, where div_n_i = 0 counts as N = 16.
- R4: In UART mode (uart_mode_i = 1) with the internal source, os_tick_o fires once per divider period and bit_tick_o fires on every 16th os_tick_o, so the bit period is 16 × tap × N clocks.
- R5: In UART mode with frac_en_i = 1, the bit period is tap × (16·N + 16 − K) clocks, where K is frac_k_i.
- R6: In fractional mode, every os_tick_o interval is tap × N or tap × (N+1) clocks, and exactly 16 − K of any 16 consecutive intervals that begin on a bit tick are the longer ones.
- R7: frac_en_i has no effect in I/O mode, and frac_k_i has no effect while frac_en_i = 0.
- R8: With ext_clk_sel_i = 1 in UART mode, os_tick_o fires once per rising edge of ext_clk_i and the bit period is 16 external periods.
- R9: With ext_clk_sel_i = 1 in I/O mode, bit_tick_o fires once per rising edge of ext_clk_i.
- R10: A new divisor written mid-period is not used until the current period has completed at full length. The period after that uses the new value.
- R11: Each strobe is high for exactly one clock. In UART mode every bit_tick_o coincides with an os_tick_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tap_sel_i | input | 2 | Prescaler tap select (0: /1, 1: /4, 2: /16, 3: /64) |
| div_n_i | input | 4 | Integer divisor N (0 means 16) |
| frac_k_i | input | 4 | Fraction K for the N + (16−K)/16 divisor |
| frac_en_i | input | 1 | Fractional divide enable, honoured in UART mode only |
| uart_mode_i | input | 1 | 1: UART mode, 0: synchronous I/O mode |
| ext_clk_sel_i | input | 1 | 1: use the external serial clock as the source |
| ext_clk_i | input | 1 | External serial clock, asynchronous |
| os_tick_o | output | 1 | 16x oversampling strobe (UART mode only) |
| bit_tick_o | output | 1 | Bit-rate strobe |

## Verification
The assertions assume that ext_clk_i stays high and low long enough for the synchroniser to see each level. That means a period of at least 4 clocks in UART mode and at least 16 in I/O mode. They also assume that mode changes come between strobes and do not race them. The bench toggles the external clock from clock-synchronous processes, with half periods of 4 and 10 clocks. It changes the settings only at falling clock edges. It discards the first intervals after each change, so that a period that is still in flight never enters a measured figure, except in the directed check where that in-flight period is the behaviour under test.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic {
    SER_IO   = 1'b0,
    SER_UART = 1'b1
  } ser_mode_e;
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int NUM_TAPS = 4,
  parameter int TAP_STEP = 2,
  localparam int SEL_W   = $clog2(NUM_TAPS),
  localparam int CNT_W   = TAP_STEP * (NUM_TAPS - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [CNT_W-1:0]    cnt_q;
  logic [NUM_TAPS-1:0] taps;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(1);

  // tap i strobes once every 2**(i*TAP_STEP) clocks
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    if (i == 0) begin : g_direct
      assign taps[i] = 1'b1;
    end else begin : g_div
      assign taps[i] = &cnt_q[i*TAP_STEP-1:0];
    end
  end

  assign tick_o = taps[sel_i];

  assert_fastest_tap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |-> tick_o);
endmodule

// File: rtl/baud_ext_sync.sv
module baud_ext_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk_i};
      last_q <= sync_q[SYNC_STAGES-1];
    end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;

  assert_single_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
  parameter int DIV_W  = 4,
  parameter int FRAC_W = 4,
  localparam int CNT_W = DIV_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DIV_W-1:0]  n_i,
  input  logic [FRAC_W-1:0] k_i,
  input  logic              frac_en_i,
  input  logic              uart_i,
  output logic              tc_o
);
  logic              primed_q;
  logic              long_q;
  logic [CNT_W-1:0]  cnt_q, act_n_q, limit, n_eff;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   inc, sum;
  logic              frac_on, load;

  assign n_eff   = (n_i == '0) ? CNT_W'(2**DIV_W) : CNT_W'(n_i);
  assign frac_on = frac_en_i & uart_i;
  assign inc     = (FRAC_W+1)'(2**FRAC_W) - {1'b0, k_i};
  assign sum     = {1'b0, acc_q} + inc;
  assign limit   = act_n_q + CNT_W'(long_q);
  assign tc_o    = primed_q & en_i & (cnt_q == limit - CNT_W'(1));
  assign load    = ~primed_q | tc_o;

  // settings are captured only at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      primed_q <= 1'b0;
      cnt_q    <= '0;
      act_n_q  <= '0;
      long_q   <= 1'b0;
      acc_q    <= '0;
    end else if (load) begin
      primed_q <= 1'b1;
      cnt_q    <= '0;
      act_n_q  <= n_eff;
      long_q   <= frac_on & sum[FRAC_W];
      acc_q    <= frac_on ? sum[FRAC_W-1:0] : '0;
    end else if (en_i) begin
      cnt_q    <= cnt_q + CNT_W'(1);
    end

  assert_cnt_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q |-> (cnt_q < limit));
  assert_limit_bounds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q |-> (limit >= CNT_W'(1) && limit <= CNT_W'(2**DIV_W + 1)));
endmodule

// File: rtl/baud_post.sv
module baud_post #(
  parameter int OS_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rate_en_i,
  input  logic uart_i,
  output logic os_tick_o,
  output logic bit_tick_o
);
  import baud_pkg::*;

  ser_mode_e       mode;
  logic [OS_W-1:0] os_cnt_q;
  logic            os_wrap;

  assign mode    = ser_mode_e'(uart_i);
  assign os_wrap = (os_cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      os_cnt_q   <= '0;
      os_tick_o  <= 1'b0;
      bit_tick_o <= 1'b0;
    end else begin
      os_tick_o  <= rate_en_i & (mode == SER_UART);
      bit_tick_o <= rate_en_i & ((mode == SER_IO) | os_wrap);
      if (mode == SER_IO)  os_cnt_q <= '0;
      else if (rate_en_i)  os_cnt_q <= os_cnt_q + OS_W'(1);
    end

  assert_bit_with_os_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_tick_o && $past(uart_i)) |-> os_tick_o);
  assert_bit_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_tick_o && uart_i) ##1 uart_i |-> !bit_tick_o);
  assert_os_quiet_io_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(uart_i) |-> !os_tick_o);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int NUM_TAPS    = 4,
  parameter int TAP_STEP    = 2,
  parameter int DIV_W       = 4,
  parameter int FRAC_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [$clog2(NUM_TAPS)-1:0] tap_sel_i,
  input  logic [DIV_W-1:0]            div_n_i,
  input  logic [FRAC_W-1:0]           frac_k_i,
  input  logic                        frac_en_i,
  input  logic                        uart_mode_i,
  input  logic                        ext_clk_sel_i,
  input  logic                        ext_clk_i,
  output logic                        os_tick_o,
  output logic                        bit_tick_o
);
  logic pre_tick, ext_rise, div_tc, rate_en;

  baud_prescaler #(.NUM_TAPS(NUM_TAPS), .TAP_STEP(TAP_STEP)) u_pre (
    .clk_i (clk_i), .rst_ni(rst_ni), .sel_i(tap_sel_i), .tick_o(pre_tick));

  baud_ext_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk_i (clk_i), .rst_ni(rst_ni), .ext_clk_i(ext_clk_i), .rise_o(ext_rise));

  baud_frac_div #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (pre_tick),
    .n_i      (div_n_i),
    .k_i      (frac_k_i),
    .frac_en_i(frac_en_i),
    .uart_i   (uart_mode_i),
    .tc_o     (div_tc));

  // external clock bypasses the N divider
  assign rate_en = ext_clk_sel_i ? ext_rise : div_tc;

  baud_post #(.OS_W(FRAC_W)) u_post (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rate_en_i (rate_en),
    .uart_i    (uart_mode_i),
    .os_tick_o (os_tick_o),
    .bit_tick_o(bit_tick_o));

  assert_ext_path_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ext_clk_sel_i) && !$past(uart_mode_i) && !$past(ext_rise)) |-> !bit_tick_o);
endmodule

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] tap_sel_i = '0;
  logic [3:0] div_n_i = '0, frac_k_i = '0;
  logic       frac_en_i = 1'b0, uart_mode_i = 1'b0;
  logic       ext_clk_sel_i = 1'b0, ext_clk_i = 1'b0;
  logic       os_tick_o, bit_tick_o;

  int n_cmp = 0, n_bad = 0;
  int ext_half = 4;
  bit ext_run = 1'b0;

  always #4 clk = ~clk;

  frac_baud_gen u_frac_baud_gen (
    .clk_i(clk), .rst_ni(rst_ni), .tap_sel_i(tap_sel_i), .div_n_i(div_n_i),
    .frac_k_i(frac_k_i), .frac_en_i(frac_en_i), .uart_mode_i(uart_mode_i),
    .ext_clk_sel_i(ext_clk_sel_i), .ext_clk_i(ext_clk_i),
    .os_tick_o(os_tick_o), .bit_tick_o(bit_tick_o));

  // {req, tap, N, K, frac_en, uart, expected bit period}
  localparam int NV = 11;
  localparam logic [31:0] VEC [NV] = '{
    {4'd5, 2'd1, 4'd7, 4'd3, 1'b1, 1'b1, 16'd500},  // R5 R2: 4*(112+13)
    {4'd4, 2'd2, 4'd5, 4'd0, 1'b0, 1'b1, 16'd1280}, // R4 R2: 16*80
    {4'd4, 2'd0, 4'd0, 4'd0, 1'b0, 1'b1, 16'd256},  // R4: N=0 as 16
    {4'd5, 2'd0, 4'd3, 4'd0, 1'b1, 1'b1, 16'd64},   // R5: K=0
    {4'd5, 2'd0, 4'd3, 4'd15, 1'b1, 1'b1, 16'd49},  // R5: K=15
    {4'd7, 2'd1, 4'd5, 4'd3, 1'b1, 1'b0, 16'd20},   // R7: frac ignored in I/O
    {4'd3, 2'd0, 4'd0, 4'd0, 1'b0, 1'b0, 16'd16},   // R3: N=0 as 16
    {4'd2, 2'd3, 4'd2, 4'd0, 1'b0, 1'b0, 16'd128},  // R2 R3: tap /64
    {4'd5, 2'd0, 4'd1, 4'd8, 1'b1, 1'b1, 16'd24},   // R5: N=1
    {4'd3, 2'd0, 4'd1, 4'd0, 1'b0, 1'b0, 16'd1},    // R3: bit every clock
    {4'd7, 2'd0, 4'd4, 4'd9, 1'b0, 1'b1, 16'd64}    // R7: K ignored
  };

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_bit(output int len);
    len = 0;
    do begin @(negedge clk); len++; end while (!bit_tick_o && len < 20000);
  endtask

  task automatic wait_os(output int len);
    len = 0;
    do begin @(negedge clk); len++; end while (!os_tick_o && len < 20000);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    forever begin
      repeat (ext_half) @(negedge clk);
      if (ext_run) ext_clk_i = ~ext_clk_i;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int len, longs, odd;
    tap_sel_i = 2'd1; div_n_i = 4'd7; frac_k_i = 4'd3; frac_en_i = 1'b1; uart_mode_i = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset os", int'(os_tick_o), 0);
    check("R1 reset bit", int'(bit_tick_o), 0);
    rst_ni = 1'b1;
    odd = 0;
    repeat (20) begin @(negedge clk); odd += int'(os_tick_o | bit_tick_o); end
    check("R1 quiet first period", odd, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      tap_sel_i = VEC[i][27:26]; div_n_i = VEC[i][25:22]; frac_k_i = VEC[i][21:18];
      frac_en_i = VEC[i][17]; uart_mode_i = VEC[i][16];
      repeat (3) wait_bit(len);
      for (int j = 0; j < 2; j++) begin
        wait_bit(len);
        check($sformatf("R%0d vector %0d", VEC[i][31:28], i), len, int'(VEC[i][15:0]));
      end
    end

    // R6 and R11: tap0, N=3, K=5 fractional
    @(negedge clk);
    tap_sel_i = 2'd0; div_n_i = 4'd3; frac_k_i = 4'd5; frac_en_i = 1'b1; uart_mode_i = 1'b1;
    repeat (3) wait_bit(len);
    check("R11 os with bit", int'(os_tick_o), 1);
    longs = 0; odd = 0;
    for (int j = 0; j < 16; j++) begin
      wait_os(len);
      if (len == 4) longs++;
      else if (len != 3) odd++;
    end
    check("R6 interval lengths", odd, 0);
    check("R6 long count", longs, 11);
    check("R11 bit ends with os", int'(bit_tick_o), 1);
    @(negedge clk);
    check("R11 one cycle wide", int'(bit_tick_o), 0);

    // R10: change N mid-period in I/O mode
    @(negedge clk);
    frac_en_i = 1'b0; uart_mode_i = 1'b0; div_n_i = 4'd10;
    repeat (3) wait_bit(len);
    div_n_i = 4'd2;
    wait_bit(len);
    check("R10 old period intact", len, 10);
    wait_bit(len);
    check("R10 new period", len, 2);

    // R8: external clock, UART, period 8
    ext_half = 4; ext_run = 1'b1; ext_clk_sel_i = 1'b1; uart_mode_i = 1'b1;
    repeat (3) wait_bit(len);
    wait_bit(len);
    check("R8 ext uart bit", len, 128);
    wait_os(len);
    check("R8 ext uart os", len, 8);

    // R9: external clock, I/O, period 20
    ext_half = 10; uart_mode_i = 1'b0;
    repeat (3) wait_bit(len);
    wait_bit(len);
    check("R9 ext io bit", len, 20);
    wait_bit(len);
    check("R9 ext io bit again", len, 20);

    // R1: reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run bit", int'(bit_tick_o), 0);
    check("R1 reset mid-run os", int'(os_tick_o), 0);

    summary();
    $finish;
  end
endmodule